// File: doc/BRIEF.md
# PWM Output Mode and Mute Controller

This block turns decoded control-register fields into the settings that steer the back end of a digital PWM audio amplifier. It chooses which of four PWM output forms is active, drives the de-emphasis filter's enable and rate code, and drives two zero-mute controls: one for the serial input data and one for the data entering the rate converter. It also picks how the design mutes when the primary clock domain is found to be asynchronous, and it produces the polarity mask for the four headphone PWM outputs.

Register fields are sampled only on a one-cycle latch strobe in the secondary master-clock domain. Output form 2 is the only form that depends on more than the form-select field. It cannot start until two noise-shaper flags from a second control word and the master-clock select pin agree with it. Once it is active, only a new form-select value can end it. This means the active form can lag behind the register contents in both directions, and a pending flag shows when that is happening. A synchronous active-high reset returns every output to its idle value.

Top module: `pwmc_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is released, the outputs hold their idle values: `active_form`=0 (form 1), `form2_pending`=0, `deemph_en`=0, `deemph_rate`=0, `in_mute`=0, `src_mute`=0, `duty50_mute`=0, `gain_zero_mute`=0, `hp_invert`=4'b1111.
- R2: Register-driven outputs change only on the clock edge that samples `latch`=1. With `latch` low, input changes leave `active_form`, `form2_pending`, `deemph_*`, `in_mute`, `src_mute` and `hp_invert` unchanged.
- R3: One cycle after a latch, `deemph_rate` equals the latched `deemph_sel`. `deemph_en` is 0 only for code 2'b00 and is 1 for any other code.
- R4: One cycle after a latch, `in_mute` follows `in_mute_bit` and `src_mute` follows `src_mute_bit` (1 = muted, 0 = released).
- R5: One cycle after `async_det`=1: if the latched `async_mode` is 0, `duty50_mute`=1 and `gain_zero_mute`=0; if it is 1, `gain_zero_mute`=1 and `duty50_mute`=0. With `async_det`=0, both are 0. The two are never high together.
- R6: `form_sel` code maps to the active-form code as 00→0 (form 1), 01→1 (form 2), 10→2 (form 3), 11→3 (form 4). `form_sel[0]` is the low field bit and `form_sel[1]` the high one. When form 2 is not active, a latch of code 00, 10 or 11 makes that form active one cycle later.
- R7: `active_form` becomes 1 (form 2) only after a latch where `form_sel`=01, `ns_5bit`=1, `ns_16x`=0 and `mclk_sel`=0 all hold together.
- R8: A latch that requests form 2 while any condition of R7 is unmet keeps the previous `active_form` and sets `form2_pending`=1. A later latch that meets all the conditions makes form 2 active and clears `form2_pending`.
- R9: While form 2 is active, latches that keep `form_sel`=01 keep form 2 active, even if `ns_5bit`, `ns_16x` or `mclk_sel` no longer meet R7. A latch with any other `form_sel` code switches to the form that code selects.
- R10: `hp_invert` bit order is [0]=L1, [1]=L2, [2]=R1, [3]=R2, where 1 means inverted relative to the power stage. With the latched `hp_phase`=0 the mask is 4'b1111. With `hp_phase`=1 it is 4'b1010. L2 and R2 are always inverted.
- R11: `form2_pending` is 1 only while form 2 is requested but not active. It is never 1 while `active_form`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary master clock |
| rst | input | 1 | Synchronous reset, active high |
| latch | input | 1 | One-cycle strobe that samples all register fields |
| deemph_sel | input | 2 | De-emphasis rate code; 00 = filter off |
| in_mute_bit | input | 1 | Zero-mute request for the serial input data |
| src_mute_bit | input | 1 | Zero-mute request for the rate-converter input |
| async_mode | input | 1 | Mute type on async detection: 0 = 50% duty, 1 = gain-stage zero |
| form_sel | input | 2 | Requested PWM output form code |
| hp_phase | input | 1 | Headphone L1/R1 phase: 0 = inverted, 1 = same as power stage |
| ns_5bit | input | 1 | Noise-shaper bit-length flag from the second word (1 = 5-bit) |
| ns_16x | input | 1 | Noise-shaper speed flag from the second word (0 = 16x rate) |
| mclk_sel | input | 1 | Master-clock select pin level |
| async_det | input | 1 | Primary side detected as asynchronous |
| active_form | output | 2 | Active PWM output form code |
| form2_pending | output | 1 | Form 2 requested but not yet active |
| deemph_en | output | 1 | De-emphasis filter enable |
| deemph_rate | output | 2 | De-emphasis rate code |
| in_mute | output | 1 | Input-data zero mute |
| src_mute | output | 1 | Rate-converter input zero mute |
| duty50_mute | output | 1 | Force PWM outputs to 50% duty |
| gain_zero_mute | output | 1 | Zero the gain-stage input |
| hp_invert | output | 4 | Headphone polarity mask (L1, L2, R1, R2) |

## Verification
Some behaviours are checked by assertions on every cycle:
- the two asynchronous mute outputs are never high together;
- the pending flag is never set while form 2 is active;
- form 2 never starts without a matching latch;
- a form-2 latch always holds form 2;
- a deferred request holds the previous form;
- the headphone channel-2 outputs stay inverted;
- outputs do not move without a latch.

Other behaviours can only be shown by the bench's scenarios. These are the ordered register sequences: requesting form 2 before the second-word flags are ready, blocking it with the clock-select pin, dropping the flags while in form 2, and then leaving through the form-select field. The scenarios also cover mapping every de-emphasis and form code to its expected output.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int RATE_W = 2;
    localparam int FORM_W = 2;

    typedef enum logic [FORM_W-1:0] {
        FORM1 = 2'd0,
        FORM2 = 2'd1,
        FORM3 = 2'd2,
        FORM4 = 2'd3
    } form_e;

    // Mode fields held from the first control word (form select kept apart)
    typedef struct packed {
        logic [RATE_W-1:0] deemph_sel;
        logic              in_mute;
        logic              src_mute;
        logic              async_sel;
        logic              hp_phase;
    } cfg_t;

    // Noise-shaper flags from the second control word
    typedef struct packed {
        logic ns_5bit;
        logic ns_16x;
    } ns_cfg_t;

    function automatic logic form2_ready(ns_cfg_t ns, logic mclk_sel);
        return ns.ns_5bit && !ns.ns_16x && !mclk_sel;
    endfunction

    function automatic form_e field_to_form(logic [FORM_W-1:0] code);
        return form_e'(code);
    endfunction

endpackage

// File: rtl/pwmc_form_fsm.sv
module pwmc_form_fsm
    import pwmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  logic [FORM_W-1:0] form_sel,
    input  ns_cfg_t           ns,
    input  logic              mclk_sel,
    output form_e             form_q,
    output logic              pending_q
);

    logic req2;
    logic ready;

    assign req2  = (field_to_form(form_sel) == FORM2);
    assign ready = form2_ready(ns, mclk_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            form_q    <= FORM1;
            pending_q <= 1'b0;
        end else if (latch) begin
            if (form_q == FORM2) begin
                // exit decided by the select field alone
                if (!req2) form_q <= field_to_form(form_sel);
                pending_q <= 1'b0;
            end else if (req2) begin
                if (ready) begin
                    form_q    <= FORM2;
                    pending_q <= 1'b0;
                end else begin
                    pending_q <= 1'b1;
                end
            end else begin
                form_q    <= field_to_form(form_sel);
                pending_q <= 1'b0;
            end
        end
    end

    assert_form2_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (form_q == FORM2 && $past(form_q) != FORM2) |->
            $past(latch && req2 && ready));

    assert_form2_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (form_q == FORM2 && latch && req2) |=> (form_q == FORM2));

    assert_defer_R8: assert property (@(posedge clk) disable iff (rst)
        (latch && req2 && !ready && form_q != FORM2) |=>
            ($stable(form_q) && pending_q));

    assert_pending_excl_R11: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> (form_q != FORM2));

endmodule

// File: rtl/pwmc_mode_regs.sv
module pwmc_mode_regs
    import pwmc_pkg::*;
#(
    parameter int HP_PAIRS = 2,
    localparam int HP_W = 2 * HP_PAIRS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  cfg_t              cfg,
    output logic              deemph_en,
    output logic [RATE_W-1:0] deemph_rate,
    output logic              in_mute,
    output logic              src_mute,
    output logic              async_sel,
    output logic [HP_W-1:0]   hp_invert
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (latch) cfg_q <= cfg;
    end

    assign deemph_en   = |cfg_q.deemph_sel;
    assign deemph_rate = cfg_q.deemph_sel;
    assign in_mute     = cfg_q.in_mute;
    assign src_mute    = cfg_q.src_mute;
    assign async_sel   = cfg_q.async_sel;

    // Each pair: channel 1 follows the phase bit, channel 2 always inverted
    for (genvar p = 0; p < HP_PAIRS; p++) begin : g_hp
        assign hp_invert[2*p]   = !cfg_q.hp_phase;
        assign hp_invert[2*p+1] = 1'b1;

        assert_hp_ch2_R10: assert property (@(posedge clk) disable iff (rst)
            latch |=> hp_invert[2*p+1]);
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !latch |=> ($stable(deemph_rate) && $stable(in_mute) &&
                    $stable(src_mute) && $stable(hp_invert)));

    assert_deemph_R3: assert property (@(posedge clk) disable iff (rst)
        latch |=> (deemph_en == ($past(cfg.deemph_sel) != '0)));

    assert_mutes_R4: assert property (@(posedge clk) disable iff (rst)
        latch |=> (in_mute == $past(cfg.in_mute) &&
                   src_mute == $past(cfg.src_mute)));

endmodule

// File: rtl/pwmc_async_mute.sv
module pwmc_async_mute (
    input  logic clk,
    input  logic rst,
    input  logic async_det,
    input  logic async_sel,
    output logic duty50_q,
    output logic gain_mute_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            duty50_q    <= 1'b0;
            gain_mute_q <= 1'b0;
        end else begin
            duty50_q    <= async_det && !async_sel;
            gain_mute_q <= async_det && async_sel;
        end
    end

    assert_mute_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(duty50_q && gain_mute_q));

    assert_duty_on_R5: assert property (@(posedge clk) disable iff (rst)
        (async_det && !async_sel) |=> duty50_q);

endmodule

// File: rtl/pwmc_ctrl.sv
module pwmc_ctrl
    import pwmc_pkg::*;
#(
    parameter int HP_PAIRS = 2,
    localparam int HP_W = 2 * HP_PAIRS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  logic [RATE_W-1:0] deemph_sel,
    input  logic              in_mute_bit,
    input  logic              src_mute_bit,
    input  logic              async_mode,
    input  logic [FORM_W-1:0] form_sel,
    input  logic              hp_phase,
    input  logic              ns_5bit,
    input  logic              ns_16x,
    input  logic              mclk_sel,
    input  logic              async_det,
    output logic [FORM_W-1:0] active_form,
    output logic              form2_pending,
    output logic              deemph_en,
    output logic [RATE_W-1:0] deemph_rate,
    output logic              in_mute,
    output logic              src_mute,
    output logic              duty50_mute,
    output logic              gain_zero_mute,
    output logic [HP_W-1:0]   hp_invert
);

    cfg_t    cfg;
    ns_cfg_t ns;
    form_e   form_q;
    logic    async_sel;

    always_comb begin
        cfg.deemph_sel = deemph_sel;
        cfg.in_mute    = in_mute_bit;
        cfg.src_mute   = src_mute_bit;
        cfg.async_sel  = async_mode;
        cfg.hp_phase   = hp_phase;
        ns.ns_5bit     = ns_5bit;
        ns.ns_16x      = ns_16x;
    end

    pwmc_form_fsm u_form (
        .clk       (clk),
        .rst       (rst),
        .latch     (latch),
        .form_sel  (form_sel),
        .ns        (ns),
        .mclk_sel  (mclk_sel),
        .form_q    (form_q),
        .pending_q (form2_pending)
    );

    pwmc_mode_regs #(.HP_PAIRS(HP_PAIRS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .latch       (latch),
        .cfg         (cfg),
        .deemph_en   (deemph_en),
        .deemph_rate (deemph_rate),
        .in_mute     (in_mute),
        .src_mute    (src_mute),
        .async_sel   (async_sel),
        .hp_invert   (hp_invert)
    );

    pwmc_async_mute u_async (
        .clk         (clk),
        .rst         (rst),
        .async_det   (async_det),
        .async_sel   (async_sel),
        .duty50_q    (duty50_mute),
        .gain_mute_q (gain_zero_mute)
    );

    assign active_form = form_q;

    assert_form_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !latch |=> ($stable(active_form) && $stable(form2_pending)));

endmodule

// File: tb/pwmc_ctrl_test.sv
module pwmc_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       latch;
    logic [1:0] deemph_sel;
    logic       in_mute_bit, src_mute_bit, async_mode;
    logic [1:0] form_sel;
    logic       hp_phase, ns_5bit, ns_16x, mclk_sel, async_det;
    logic [1:0] active_form;
    logic       form2_pending, deemph_en;
    logic [1:0] deemph_rate;
    logic       in_mute, src_mute, duty50_mute, gain_zero_mute;
    logic [3:0] hp_invert;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwmc_ctrl uut (
        .clk(clk), .rst(rst), .latch(latch),
        .deemph_sel(deemph_sel), .in_mute_bit(in_mute_bit),
        .src_mute_bit(src_mute_bit), .async_mode(async_mode),
        .form_sel(form_sel), .hp_phase(hp_phase),
        .ns_5bit(ns_5bit), .ns_16x(ns_16x), .mclk_sel(mclk_sel),
        .async_det(async_det),
        .active_form(active_form), .form2_pending(form2_pending),
        .deemph_en(deemph_en), .deemph_rate(deemph_rate),
        .in_mute(in_mute), .src_mute(src_mute),
        .duty50_mute(duty50_mute), .gain_zero_mute(gain_zero_mute),
        .hp_invert(hp_invert)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // fields set at a falling edge, strobed for one cycle, sampled after
    task automatic do_latch();
        @(negedge clk) latch = 1'b1;
        @(negedge clk) latch = 1'b0;
    endtask

    task automatic t_reset_R1();
        chk("R1 form", {6'b0, active_form}, 8'd0);
        chk("R1 pending", {7'b0, form2_pending}, 8'd0);
        chk("R1 deemph", {5'b0, deemph_en, deemph_rate}, 8'd0);
        chk("R1 mutes", {4'b0, in_mute, src_mute, duty50_mute, gain_zero_mute}, 8'd0);
        chk("R1 hp", {4'b0, hp_invert}, 8'hF);
    endtask

    task automatic t_deemph_R3();
        for (int c = 0; c < 4; c++) begin
            deemph_sel = c[1:0];
            do_latch();
            chk("R3 rate", {6'b0, deemph_rate}, 8'(c));
            chk("R3 enable", {7'b0, deemph_en}, (c == 0) ? 8'd0 : 8'd1);
        end
    endtask

    task automatic t_mutes_R4();
        in_mute_bit = 1'b1; src_mute_bit = 1'b0; do_latch();
        chk("R4 in/src 10", {6'b0, in_mute, src_mute}, 8'b10);
        in_mute_bit = 1'b0; src_mute_bit = 1'b1; do_latch();
        chk("R4 in/src 01", {6'b0, in_mute, src_mute}, 8'b01);
        src_mute_bit = 1'b0; do_latch();
        chk("R4 released", {6'b0, in_mute, src_mute}, 8'b00);
    endtask

    task automatic t_no_latch_R2();
        @(negedge clk);
        deemph_sel = 2'd2; in_mute_bit = 1'b1; hp_phase = 1'b1; form_sel = 2'd3;
        repeat (3) @(negedge clk);
        chk("R2 form held", {6'b0, active_form}, 8'd0);
        chk("R2 deemph held", {5'b0, deemph_en, deemph_rate}, 8'd0);
        chk("R2 mute held", {7'b0, in_mute}, 8'd0);
        chk("R2 hp held", {4'b0, hp_invert}, 8'hF);
        deemph_sel = 2'd0; in_mute_bit = 1'b0; hp_phase = 1'b0; form_sel = 2'd0;
    endtask

    task automatic t_forms_R6();
        form_sel = 2'd2; do_latch();
        chk("R6 code 10", {6'b0, active_form}, 8'd2);
        form_sel = 2'd3; do_latch();
        chk("R6 code 11", {6'b0, active_form}, 8'd3);
        form_sel = 2'd0; do_latch();
        chk("R6 code 00", {6'b0, active_form}, 8'd0);
    endtask

    task automatic t_defer_R8();
        form_sel = 2'd2; do_latch();
        form_sel = 2'd1; ns_5bit = 1'b0; ns_16x = 1'b0; mclk_sel = 1'b0; do_latch();
        chk("R8 held form3", {6'b0, active_form}, 8'd2);
        chk("R11 pending set", {7'b0, form2_pending}, 8'd1);
        ns_5bit = 1'b1; mclk_sel = 1'b1; do_latch();
        chk("R7 pin blocks", {6'b0, active_form}, 8'd2);
        ns_16x = 1'b1; mclk_sel = 1'b0; do_latch();
        chk("R7 speed blocks", {6'b0, active_form}, 8'd2);
        ns_16x = 1'b0; do_latch();
        chk("R8 entered", {6'b0, active_form}, 8'd1);
        chk("R11 pending clear", {7'b0, form2_pending}, 8'd0);
    endtask

    task automatic t_exit_R9();
        ns_5bit = 1'b0; ns_16x = 1'b1; mclk_sel = 1'b1; do_latch();
        chk("R9 flags dropped", {6'b0, active_form}, 8'd1);
        chk("R9 no pending", {7'b0, form2_pending}, 8'd0);
        form_sel = 2'd3; do_latch();
        chk("R9 exit to form4", {6'b0, active_form}, 8'd3);
        form_sel = 2'd1; do_latch();
        chk("R7 not re-entered", {6'b0, active_form}, 8'd3);
        form_sel = 2'd0; ns_16x = 1'b0; mclk_sel = 1'b0; do_latch();
        chk("R11 pending clears", {7'b0, form2_pending}, 8'd0);
    endtask

    task automatic t_async_R5();
        async_mode = 1'b0; do_latch();
        @(negedge clk) async_det = 1'b1;
        @(negedge clk);
        chk("R5 duty50", {6'b0, duty50_mute, gain_zero_mute}, 8'b10);
        async_mode = 1'b1; do_latch();
        @(negedge clk);
        chk("R5 gain zero", {6'b0, duty50_mute, gain_zero_mute}, 8'b01);
        async_det = 1'b0;
        @(negedge clk);
        chk("R5 idle", {6'b0, duty50_mute, gain_zero_mute}, 8'b00);
    endtask

    task automatic t_hp_R10();
        hp_phase = 1'b1; do_latch();
        chk("R10 phase1", {4'b0, hp_invert}, 8'hA);
        hp_phase = 1'b0; do_latch();
        chk("R10 phase0", {4'b0, hp_invert}, 8'hF);
    endtask

    initial begin
        rst = 1'b1; latch = 1'b0; deemph_sel = '0; in_mute_bit = 1'b0;
        src_mute_bit = 1'b0; async_mode = 1'b0; form_sel = '0; hp_phase = 1'b0;
        ns_5bit = 1'b0; ns_16x = 1'b0; mclk_sel = 1'b0; async_det = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_R1();
        rst = 1'b0;
        @(negedge clk);
        t_reset_R1();
        t_no_latch_R2();
        t_deemph_R3();
        t_mutes_R4();
        t_forms_R6();
        t_defer_R8();
        t_exit_R9();
        t_async_R5();
        t_hp_R10();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule